// File: doc/BRIEF.md
# Status-Bit Predicated Select Unit

This unit decodes and executes a small group of instructions that exist only while the processor runs in its tags-active mode. The main group is a conditional select: it tests one bit of the 64-bit fixed-point status register and writes one of two operands to a destination register. Each operand is either a general register or a zero-extended 5-bit immediate. Record forms of the select also produce a three-bit condition field that classifies the written value as a signed number. The unit also decodes two further instructions. The first is a trap that fires on the value of a status bit. The second is the tag-set instruction, which asks the owner of the status register to set the tag bit (MSB-0 bit 43, LSB-0 bit 20).

The issue stage presents an instruction word with a valid strobe, the current status register and the mode bit. The unit drives two register-file read addresses taken straight from the instruction word, and the register file returns the data in the same cycle. Every result appears on registered outputs one clock after the instruction is accepted. When the mode bit is clear, a recognised instruction produces only an illegal-instruction flag.

Top module: `psel_unit`

## Requirements
- R1: After a synchronous active-low reset, every output strobe (`wb_valid_o`, `cr_valid_o`, `trap_o`, `illegal_o`, `set_tag_o`) is 0.
- R2: A select has major opcode 30 in instruction bits [31:26] (LSB-0) and a minor opcode of 24..31 in bits [4:0]. When the tested status bit is 1, the first operand is written to the register named in bits [20:16], with `wb_valid_o` high one clock after the instruction is accepted.
- R3: When the tested status bit is 0, the select writes the second operand instead.
- R4: The first operand field is bits [25:21] and the second is bits [15:11]. Minor 24/25 makes both immediate, 26/27 makes the first immediate and the second a register, 28/29 makes the first a register and the second immediate, and 30/31 makes both registers. Immediates are zero-extended to 64 bits.
- R5: The 4-bit field in bits [10:7], value k, picks MSB-0 status bit 32+k, which is LSB-0 bit 31-k.
- R6: Odd minor opcodes also raise `cr_valid_o` with `cr_o` = 3'b100 for a negative result, 3'b010 for a positive result and 3'b001 for zero, taking the result as signed. Even minor opcodes leave `cr_valid_o` low.
- R7: A trap has major opcode 31 and minor opcode 36 in bits [6:1]. It raises `trap_o` exactly when the tested status bit (chosen as in R5) equals bit [21], and it writes no register.
- R8: The word 0x7C0103E6 raises `set_tag_o` for one cycle and writes no register.
- R9: With `tags_active_i` low, any select, trap or tag-set raises only `illegal_o`. No writeback, condition update, trap or tag-set occurs.
- R10: A cycle with `instr_valid_i` low, or with an instruction outside this group, raises no output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| status_i | input | 64 | Fixed-point status register |
| tags_active_i | input | 1 | Tags-active mode bit |
| rd_a_addr_o | output | 5 | Register-file read address for the first operand |
| rd_a_data_i | input | 64 | Register-file read data for the first operand |
| rd_b_addr_o | output | 5 | Register-file read address for the second operand |
| rd_b_data_i | input | 64 | Register-file read data for the second operand |
| wb_valid_o | output | 1 | Register writeback strobe |
| wb_addr_o | output | 5 | Writeback register number |
| wb_data_o | output | 64 | Writeback value |
| cr_valid_o | output | 1 | Condition field update strobe |
| cr_o | output | 3 | Condition field {negative, positive, zero} |
| trap_o | output | 1 | Trap taken |
| illegal_o | output | 1 | Illegal-instruction flag |
| set_tag_o | output | 1 | Request to set the status tag bit |

## Verification
The bench exercises the extreme values of the bit index (0 and 15) and the tag bit's own index. A design that indexed the status register from the wrong end, or without the 32-bit offset, would pick the wrong operand there. All four operand variants are run with register contents that differ from the immediate values, so a swapped immediate/register decode shows up as a wrong writeback. Record forms are run with negative, positive and zero results and with a large immediate, which catches an unsigned comparison or a mis-ordered condition code. The trap is run with both compare values, and every instruction kind is reissued with the mode bit clear to make sure nothing other than the illegal flag leaks out.

// File: rtl/psel_pkg.sv
// Shared types for the predicated select unit.
// Assumes a 32-bit instruction word and a 64-bit status register.
package psel_pkg;
    localparam int XLEN = 64;
    localparam int RIDX = 5;

    typedef enum logic [1:0] {
        OPK_NONE   = 2'd0,
        OPK_SELECT = 2'd1,
        OPK_TRAP   = 2'd2,
        OPK_TAGSET = 2'd3
    } opkind_e;

    typedef struct packed {
        opkind_e         kind;
        logic            record;
        logic            a_is_imm;
        logic            b_is_imm;
        logic [RIDX-1:0] a_fld;
        logic [RIDX-1:0] b_fld;
        logic [RIDX-1:0] dst;
        logic [3:0]      bit_sel;
        logic            trap_val;
    } dec_t;
endpackage

// File: rtl/psel_decode.sv
// Instruction decoder for the select, trap and tag-set group.
// Purely combinational. It assumes LSB-0 numbering of the instruction word.
// Words that do not belong to the group decode as OPK_NONE.
module psel_decode
    import psel_pkg::*;
#(
    parameter logic [5:0]  SEL_MAJOR  = 6'd30,
    parameter logic [5:0]  TRAP_MAJOR = 6'd31,
    parameter logic [5:0]  TRAP_MINOR = 6'd36,
    parameter logic [31:0] TAGSET_WORD = 32'h7C0103E6
) (
    input  logic [31:0] instr_i,
    output dec_t        dec_o
);
    logic [5:0] major;
    logic [4:0] sel_minor;
    logic       unused_bits;

    assign major       = instr_i[31:26];
    assign sel_minor   = instr_i[4:0];
    assign unused_bits = ^{instr_i[6:5], instr_i[20:11], instr_i[0]};

    // Classify the word and pull out its fields.
    always_comb begin
        dec_o          = '0;
        dec_o.kind     = OPK_NONE;
        dec_o.a_fld    = instr_i[25:21];
        dec_o.dst      = instr_i[20:16];
        dec_o.b_fld    = instr_i[15:11];
        dec_o.bit_sel  = instr_i[10:7];
        dec_o.trap_val = instr_i[21];
        dec_o.record   = sel_minor[0];
        dec_o.a_is_imm = ~sel_minor[2];
        dec_o.b_is_imm = ~sel_minor[1];
        if (instr_i == TAGSET_WORD) begin
            dec_o.kind = OPK_TAGSET;
        end else if (major == SEL_MAJOR && sel_minor[4:3] == 2'b11) begin
            dec_o.kind = OPK_SELECT;
        end else if (major == TRAP_MAJOR && instr_i[6:1] == TRAP_MINOR) begin
            dec_o.kind = OPK_TRAP;
        end
    end
endmodule

// File: rtl/psel_exec.sv
// Datapath: tests the chosen status bit, selects the operand and classifies it.
// Combinational. It assumes register read data arrives in the same cycle.
// The 4-bit index k maps to MSB-0 status bit 32+k.
module psel_exec
    import psel_pkg::*;
#(
    parameter int W       = XLEN,
    parameter int SEL_MSB0 = 32
) (
    input  dec_t          dec_i,
    input  logic [W-1:0]  status_i,
    input  logic [W-1:0]  a_data_i,
    input  logic [W-1:0]  b_data_i,
    output logic          tbit_o,
    output logic [W-1:0]  result_o,
    output logic [2:0]    cr_o
);
    localparam int SEL_LSB = W - 1 - SEL_MSB0;

    logic [W-1:0] op_a;
    logic [W-1:0] op_b;

    // Pick the tested status bit.
    always_comb tbit_o = status_i[SEL_LSB - int'(dec_i.bit_sel)];

    // Form both operands from an immediate or a register.
    always_comb begin
        op_a = dec_i.a_is_imm ? {{(W-RIDX){1'b0}}, dec_i.a_fld} : a_data_i;
        op_b = dec_i.b_is_imm ? {{(W-RIDX){1'b0}}, dec_i.b_fld} : b_data_i;
    end

    // Choose the result and classify it as signed.
    always_comb begin
        result_o = tbit_o ? op_a : op_b;
        if (result_o[W-1])       cr_o = 3'b100;
        else if (result_o == '0) cr_o = 3'b001;
        else                     cr_o = 3'b010;
    end
endmodule

// File: rtl/psel_unit.sv
// Top of the predicated select unit. It registers all results one cycle after issue.
// Assumes the register file answers reads combinationally.
// The mode bit gates every effect of the group into the illegal flag.
module psel_unit
    import psel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid_i,
    input  logic [31:0]         instr_i,
    input  logic [XLEN-1:0]     status_i,
    input  logic                tags_active_i,
    output logic [RIDX-1:0]     rd_a_addr_o,
    input  logic [XLEN-1:0]     rd_a_data_i,
    output logic [RIDX-1:0]     rd_b_addr_o,
    input  logic [XLEN-1:0]     rd_b_data_i,
    output logic                wb_valid_o,
    output logic [RIDX-1:0]     wb_addr_o,
    output logic [XLEN-1:0]     wb_data_o,
    output logic                cr_valid_o,
    output logic [2:0]          cr_o,
    output logic                trap_o,
    output logic                illegal_o,
    output logic                set_tag_o
);
    dec_t            dec;
    logic            tbit;
    logic [XLEN-1:0] result;
    logic [2:0]      cr_next;
    logic            ours;
    logic            legal;

    psel_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    psel_exec #(.W(XLEN)) u_exec (
        .dec_i(dec), .status_i(status_i),
        .a_data_i(rd_a_data_i), .b_data_i(rd_b_data_i),
        .tbit_o(tbit), .result_o(result), .cr_o(cr_next)
    );

    assign rd_a_addr_o = dec.a_fld;
    assign rd_b_addr_o = dec.b_fld;

    // Qualify the decoded instruction with valid and mode.
    always_comb begin
        ours  = instr_valid_i && (dec.kind != OPK_NONE);
        legal = ours && tags_active_i;
    end

    // Register every output one cycle after issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid_o <= 1'b0;
            wb_addr_o  <= '0;
            wb_data_o  <= '0;
            cr_valid_o <= 1'b0;
            cr_o       <= '0;
            trap_o     <= 1'b0;
            illegal_o  <= 1'b0;
            set_tag_o  <= 1'b0;
        end else begin
            wb_valid_o <= legal && dec.kind == OPK_SELECT;
            cr_valid_o <= legal && dec.kind == OPK_SELECT && dec.record;
            trap_o     <= legal && dec.kind == OPK_TRAP && (tbit == dec.trap_val);
            set_tag_o  <= legal && dec.kind == OPK_TAGSET;
            illegal_o  <= ours && !tags_active_i;
            if (legal && dec.kind == OPK_SELECT) begin
                wb_addr_o <= dec.dst;
                wb_data_o <= result;
                cr_o      <= cr_next;
            end
        end
    end

    // R9: an illegal instruction has no other effect.
    a_r9_illegal_alone: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(wb_valid_o || cr_valid_o || trap_o || set_tag_o));

    // R10: nothing comes out of a cycle without a valid instruction.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(instr_valid_i) |-> !(wb_valid_o || cr_valid_o || trap_o || illegal_o || set_tag_o));

    // R6: a condition update only comes with a writeback and is one-hot.
    a_r6_cr_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid_o |-> (wb_valid_o && $onehot(cr_o)));

    // R6: the negative flag tracks the sign of the written value.
    a_r6_cr_sign: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid_o |-> (cr_o[2] == wb_data_o[XLEN-1]));

    // R7 and R8: trap and tag-set never write a register.
    a_r7_trap_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o || set_tag_o) |-> !wb_valid_o);

    // R9: clear mode on a valid instruction never writes back.
    a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(instr_valid_i) && !$past(tags_active_i)) |-> !wb_valid_o);
endmodule

// File: tb/psel_unit_tb_top.sv
`timescale 1ns/1ps
module psel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] status = '0;
    logic        mode = 1'b1;
    logic [4:0]  ra_addr, rb_addr;
    logic [63:0] ra_data, rb_data;
    logic        wb_valid, cr_valid, trap, illegal, set_tag;
    logic [4:0]  wb_addr;
    logic [63:0] wb_data;
    logic [2:0]  cr;
    int          n_tests = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #4 clk = ~clk;

    // Model register file: odd registers negative, even positive, r0 zero.
    function automatic logic [63:0] rfval(input logic [4:0] i);
        if (i == 5'd0) return 64'd0;
        if (i[0])      return 64'hFFFF_FFFF_FFFF_FF00 | {59'd0, i};
        return 64'h0000_0100_0000_0000 | {59'd0, i};
    endfunction
    assign ra_data = rfval(ra_addr);
    assign rb_data = rfval(rb_addr);

    psel_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
        .status_i(status), .tags_active_i(mode),
        .rd_a_addr_o(ra_addr), .rd_a_data_i(ra_data),
        .rd_b_addr_o(rb_addr), .rd_b_data_i(rb_data),
        .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
        .cr_valid_o(cr_valid), .cr_o(cr), .trap_o(trap),
        .illegal_o(illegal), .set_tag_o(set_tag)
    );

    function automatic logic [31:0] sel_w(input logic [4:0] minor, input logic [4:0] d,
                                          input logic [4:0] a, input logic [4:0] b,
                                          input logic [3:0] k);
        return {6'd30, a, d, b, k, 2'b00, minor};
    endfunction
    function automatic logic [31:0] trap_w(input logic v, input logic [3:0] k);
        return {6'd31, 4'd0, v, 10'h155, k, 6'd36, 1'b0};
    endfunction
    function automatic logic [63:0] st_bit(input logic [3:0] k);
        return 64'd1 << (31 - k);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one instruction and leave outputs ready for sampling at the next negedge.
    task automatic issue(input logic [31:0] w, input logic [63:0] st, input logic m);
        @(negedge clk);
        instr = w; status = st; mode = m; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic chk_sel(input string req, input logic [63:0] exp, input logic [4:0] d);
        chk(wb_valid && wb_addr == d && wb_data == exp, req, wb_data, exp);
    endtask

    task automatic t_reset;
        chk(!(wb_valid || cr_valid || trap || illegal || set_tag), "R1",
            {59'd0, wb_valid, cr_valid, trap, illegal, set_tag}, 64'd0);
    endtask

    task automatic t_basic;
        issue(sel_w(5'd30, 5'd7, 5'd4, 5'd6, 4'd3), st_bit(4'd3), 1'b1);
        chk_sel("R2", rfval(5'd4), 5'd7);
        chk(!cr_valid, "R6 even minor", {63'd0, cr_valid}, 64'd0);
        issue(sel_w(5'd30, 5'd7, 5'd4, 5'd6, 4'd3), ~st_bit(4'd3), 1'b1);
        chk_sel("R3", rfval(5'd6), 5'd7);
    endtask

    task automatic t_variants;
        issue(sel_w(5'd24, 5'd1, 5'd9, 5'd12, 4'd0), st_bit(4'd0), 1'b1);
        chk_sel("R4 imm-imm first", 64'd9, 5'd1);
        issue(sel_w(5'd24, 5'd1, 5'd9, 5'd12, 4'd0), 64'd0, 1'b1);
        chk_sel("R4 imm-imm second", 64'd12, 5'd1);
        issue(sel_w(5'd26, 5'd2, 5'd9, 5'd12, 4'd0), st_bit(4'd0), 1'b1);
        chk_sel("R4 imm-reg first", 64'd9, 5'd2);
        issue(sel_w(5'd26, 5'd2, 5'd9, 5'd12, 4'd0), 64'd0, 1'b1);
        chk_sel("R4 imm-reg second", rfval(5'd12), 5'd2);
        issue(sel_w(5'd28, 5'd3, 5'd9, 5'd12, 4'd0), st_bit(4'd0), 1'b1);
        chk_sel("R4 reg-imm first", rfval(5'd9), 5'd3);
        issue(sel_w(5'd28, 5'd3, 5'd9, 5'd12, 4'd0), 64'd0, 1'b1);
        chk_sel("R4 reg-imm second", 64'd12, 5'd3);
    endtask

    task automatic t_index;
        issue(sel_w(5'd30, 5'd5, 5'd2, 5'd4, 4'd15), st_bit(4'd15), 1'b1);
        chk_sel("R5 k=15", rfval(5'd2), 5'd5);
        issue(sel_w(5'd30, 5'd5, 5'd2, 5'd4, 4'd15), ~st_bit(4'd15), 1'b1);
        chk_sel("R5 k=15 clear", rfval(5'd4), 5'd5);
        issue(sel_w(5'd30, 5'd5, 5'd2, 5'd4, 4'd11), 64'h0000_0000_0010_0000, 1'b1);
        chk_sel("R5 tag bit k=11", rfval(5'd2), 5'd5);
        issue(sel_w(5'd30, 5'd5, 5'd2, 5'd4, 4'd0), 64'h0000_0001_0000_0001, 1'b1);
        chk_sel("R5 outside window", rfval(5'd4), 5'd5);
    endtask

    task automatic t_record;
        issue(sel_w(5'd31, 5'd8, 5'd3, 5'd4, 4'd1), st_bit(4'd1), 1'b1);
        chk(cr_valid && cr == 3'b100, "R6 negative", {61'd0, cr}, 64'd4);
        issue(sel_w(5'd31, 5'd8, 5'd3, 5'd4, 4'd1), 64'd0, 1'b1);
        chk(cr_valid && cr == 3'b010, "R6 positive", {61'd0, cr}, 64'd2);
        issue(sel_w(5'd29, 5'd8, 5'd0, 5'd4, 4'd1), st_bit(4'd1), 1'b1);
        chk(cr_valid && cr == 3'b001, "R6 zero", {61'd0, cr}, 64'd1);
        issue(sel_w(5'd25, 5'd8, 5'd31, 5'd0, 4'd1), st_bit(4'd1), 1'b1);
        chk(cr_valid && cr == 3'b010 && wb_data == 64'd31, "R6 imm 31",
            {61'd0, cr}, 64'd2);
    endtask

    task automatic t_trap;
        issue(trap_w(1'b1, 4'd6), st_bit(4'd6), 1'b1);
        chk(trap && !wb_valid, "R7 match one", {63'd0, trap}, 64'd1);
        issue(trap_w(1'b0, 4'd6), st_bit(4'd6), 1'b1);
        chk(!trap, "R7 mismatch", {63'd0, trap}, 64'd0);
        issue(trap_w(1'b0, 4'd6), ~st_bit(4'd6), 1'b1);
        chk(trap && !wb_valid, "R7 match zero", {63'd0, trap}, 64'd1);
    endtask

    task automatic t_tagset;
        issue(32'h7C0103E6, 64'd0, 1'b1);
        chk(set_tag && !wb_valid && !illegal, "R8", {63'd0, set_tag}, 64'd1);
        @(negedge clk);
        chk(!set_tag, "R8 single pulse", {63'd0, set_tag}, 64'd0);
    endtask

    task automatic t_illegal;
        issue(sel_w(5'd31, 5'd7, 5'd4, 5'd6, 4'd3), st_bit(4'd3), 1'b0);
        chk(illegal && !wb_valid && !cr_valid, "R9 select", {63'd0, wb_valid}, 64'd0);
        issue(trap_w(1'b1, 4'd6), st_bit(4'd6), 1'b0);
        chk(illegal && !trap, "R9 trap", {63'd0, trap}, 64'd0);
        issue(32'h7C0103E6, 64'd0, 1'b0);
        chk(illegal && !set_tag, "R9 tagset", {63'd0, set_tag}, 64'd0);
    endtask

    task automatic t_other;
        @(negedge clk);
        instr = sel_w(5'd30, 5'd7, 5'd4, 5'd6, 4'd3); mode = 1'b1; instr_valid = 1'b0;
        @(negedge clk);
        chk(!(wb_valid || illegal), "R10 not valid", {63'd0, wb_valid}, 64'd0);
        issue(sel_w(5'd20, 5'd7, 5'd4, 5'd6, 4'd3), st_bit(4'd3), 1'b0);
        chk(!(wb_valid || illegal), "R10 minor below 24", {63'd0, illegal}, 64'd0);
        issue({6'd12, 26'h3FFFFFF}, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        chk(!(wb_valid || trap || set_tag || illegal), "R10 foreign opcode",
            {63'd0, wb_valid}, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_variants();
        t_index();
        t_record();
        t_trap();
        t_tagset();
        t_illegal();
        t_other();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule